// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment-relative reference (a segment number and a 32-bit offset) into a 32-bit linear address. It holds six segment registers. Each pairs a visible 16-bit selector with a hidden cached copy of its descriptor: base, limit, privilege level and a valid flag. The current privilege level is read from the low two bits of the code segment's selector.

Loading a register starts a descriptor fetch. The unit sends a 32-bit address over a valid/ready read port and waits for a 64-bit response. It checks privilege once, at that point. It then either caches the descriptor or reports a protection fault. Once a register is loaded, a reference through it only compares the offset against the cached limit and adds the base. Privilege is not checked again.

Data segment registers are loaded through an ordinary load port. The code segment can be written only through a separate control-transfer input, which is the only path that changes the privilege level.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset all six registers are flat: base 0, limit 0xFFFFFFFF, level 0, valid. Every reference returns its offset unchanged, and the privilege level output reads 0.
- R2: A selector carries its requested level in bits [1:0], the table choice in bit 2 (0 selects the global table base, 1 the local one) and an entry number in bits [15:3]. The fetch address is the chosen table base plus entry number × 8.
- R3: The 64-bit descriptor response holds the base in bits [31:0], a 30-bit limit in bits [61:32] (zero-extended to 32 bits) and the level in bits [63:62]. On success the register takes that descriptor and the new selector, which then shows in `sel_view` at bits [16*n+15:16*n] for register n.
- R4: A data register load faults with code 1 (privilege) when the larger of the current level and the requested level exceeds the descriptor level. The register is then left unchanged.
- R5: Register 0 (code) loads only through `xfer_valid`. That path faults with code 1 when the selector's requested level exceeds the descriptor level, whatever the current level is. On success the privilege level output becomes the selector's requested level.
- R6: A load request naming register 0 or a number of 6 or more is ignored: no fetch, no done, no fault, and no register changes.
- R7: A selector whose bits [15:2] are all zero is null. A null load into registers 1, 3, 4 or 5 issues no fetch and reports done in the next cycle. The register is marked invalid, and later references through it fault with code 3.
- R8: A null load into register 2 (stack) or through the transfer input faults with code 3 and changes nothing.
- R9: A reference yields, one cycle later, either `lin_valid` with base + offset modulo 2^32, or a fault with code 2 when the offset exceeds the limit. An invalid register or a register number of 6 or more gives code 3 instead.
- R10: Only one load is in flight. `ld_ready` is low from acceptance to completion, and the fetch request holds its address until it is taken.
- R11: Privilege is not checked again on references. A register loaded earlier stays usable after the privilege level changes.
- R12: A reference made in the same cycle a load commits to the same register uses the previous descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Data register load request |
| ld_seg | input | 3 | Register number for the load |
| ld_sel | input | 16 | Selector to load |
| ld_ready | output | 1 | Idle, able to accept a load |
| xfer_valid | input | 1 | Control-transfer code register load |
| xfer_sel | input | 16 | Selector for the code register |
| gdt_base | input | 32 | Global table base |
| ldt_base | input | 32 | Local table base |
| rd_req_valid | output | 1 | Descriptor fetch request |
| rd_req_ready | input | 1 | Fetch request taken |
| rd_req_addr | output | 32 | Fetch address |
| rd_rsp_valid | input | 1 | Fetch response valid |
| rd_rsp_data | input | 64 | Fetched descriptor |
| ld_done | output | 1 | One-cycle pulse: load committed |
| ld_fault | output | 1 | One-cycle pulse: load refused |
| ld_fault_code | output | 2 | 1 privilege, 3 null |
| acc_valid | input | 1 | Reference request |
| acc_seg | input | 3 | Register number for the reference |
| acc_off | input | 32 | Offset |
| lin_valid | output | 1 | Linear address valid |
| lin_addr | output | 32 | Linear address |
| acc_fault | output | 1 | Reference fault pulse |
| acc_fault_code | output | 2 | 2 limit, 3 null/invalid |
| cpl | output | 2 | Current privilege level |
| sel_view | output | 96 | Visible selectors, register n at [16n+15:16n] |

## Verification
A reference and a load commit can land on the same clock edge and target the same register. The reference must then see the descriptor as it was before the commit. To provoke this, the bench raises `acc_valid` for a data register in the same cycle it drives the fetch response for that register, which was previously loaded null. It expects a code-3 fault, because the old descriptor was invalid. The reference that follows must produce the new base plus offset.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int LIN_W  = 32;
   localparam int SEL_W  = 16;
   localparam int DESC_W = 64;
   localparam int LIM_W  = 30;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_PRIV  = 2'd1,
      FLT_LIMIT = 2'd2,
      FLT_NULL  = 2'd3
   } flt_e;

   typedef struct packed {
      logic [LIN_W-1:0] base;
      logic [LIN_W-1:0] limit;
      logic [1:0]       dpl;
      logic             valid;
   } seg_desc_t;

   function automatic seg_desc_t desc_flat();
      seg_desc_t d;
      d.base  = '0;
      d.limit = '1;
      d.dpl   = 2'd0;
      d.valid = 1'b1;
      return d;
   endfunction

   function automatic seg_desc_t desc_unpack(input logic [DESC_W-1:0] raw);
      seg_desc_t d;
      d.base  = raw[LIN_W-1:0];
      d.limit = {{(LIN_W-LIM_W){1'b0}}, raw[LIN_W+LIM_W-1:LIN_W]};
      d.dpl   = raw[DESC_W-1:DESC_W-2];
      d.valid = 1'b1;
      return d;
   endfunction

endpackage

// File: rtl/seg_reg_file.sv
module seg_reg_file
   import seg_xlate_pkg::*;
#(
   parameter int NUM_SEG = 6,
   localparam int SEG_W  = $clog2(NUM_SEG)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEG_W-1:0]         wr_idx,
   input  logic [SEL_W-1:0]         wr_sel,
   input  seg_desc_t                wr_desc,
   input  logic [SEG_W-1:0]         rd_idx,
   output seg_desc_t                rd_desc,
   output logic [1:0]               cur_pl,
   output logic [NUM_SEG*SEL_W-1:0] sel_flat
);

   seg_desc_t        desc_w [NUM_SEG];
   logic [SEL_W-1:0] sel_w  [NUM_SEG];

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
      seg_desc_t        desc_q;
      logic [SEL_W-1:0] sel_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            desc_q <= desc_flat();
            sel_q  <= '0;
         end else if (wr_en && (int'(wr_idx) == g)) begin
            desc_q <= wr_desc;
            sel_q  <= wr_sel;
         end
      end

      assign desc_w[g] = desc_q;
      assign sel_w[g]  = sel_q;
      assign sel_flat[g*SEL_W +: SEL_W] = sel_q;
   end

   always_comb begin
      rd_desc = '0;
      for (int i = 0; i < NUM_SEG; i++) begin
         if (int'(rd_idx) == i) rd_desc = desc_w[i];
      end
   end

   assign cur_pl = sel_w[0][1:0];

endmodule

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
   import seg_xlate_pkg::*;
#(
   parameter int NUM_SEG = 6,
   parameter int STK_SEG = 2,
   localparam int SEG_W  = $clog2(NUM_SEG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_valid,
   input  logic [SEG_W-1:0]   ld_seg,
   input  logic [SEL_W-1:0]   ld_sel,
   input  logic               xfer_valid,
   input  logic [SEL_W-1:0]   xfer_sel,
   input  logic [LIN_W-1:0]   gdt_base,
   input  logic [LIN_W-1:0]   ldt_base,
   input  logic [1:0]         cur_pl,
   output logic               ld_ready,
   output logic               rd_req_valid,
   input  logic               rd_req_ready,
   output logic [LIN_W-1:0]   rd_req_addr,
   input  logic               rd_rsp_valid,
   input  logic [DESC_W-1:0]  rd_rsp_data,
   output logic               wr_en,
   output logic [SEG_W-1:0]   wr_idx,
   output logic [SEL_W-1:0]   wr_sel,
   output seg_desc_t          wr_desc,
   output logic               ld_done,
   output logic [1:0]         ld_fault_code,
   output logic               ld_fault
);

   typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

   st_e              st_q, st_d;
   logic [SEG_W-1:0] tgt_idx_q;
   logic [SEL_W-1:0] tgt_sel_q;
   logic             tgt_cs_q;
   logic [LIN_W-1:0] addr_q;
   logic             done_q, done_d;
   flt_e             flt_q, flt_d;

   logic             take_ld, start, in_null, null_bad, priv_bad;
   logic [SEL_W-1:0] in_sel;
   logic [SEG_W-1:0] in_idx;
   logic [LIN_W-1:0] tbl_addr;
   logic [1:0]       rpl, eff_pl;
   seg_desc_t        rsp_desc;

   assign take_ld  = ld_valid && (ld_seg != '0) && (int'(ld_seg) < NUM_SEG);
   assign start    = (st_q == S_IDLE) && (xfer_valid || take_ld);
   assign in_sel   = xfer_valid ? xfer_sel : ld_sel;
   assign in_idx   = xfer_valid ? '0 : ld_seg;
   assign in_null  = (in_sel[SEL_W-1:2] == '0);
   assign null_bad = (in_idx == '0) || (in_idx == SEG_W'(STK_SEG));
   assign tbl_addr = (in_sel[2] ? ldt_base : gdt_base)
                   + {{(LIN_W-SEL_W){1'b0}}, in_sel[SEL_W-1:3], 3'b000};

   assign rsp_desc = desc_unpack(rd_rsp_data);
   assign rpl      = tgt_sel_q[1:0];
   assign eff_pl   = (tgt_cs_q || (rpl > cur_pl)) ? rpl : cur_pl;
   assign priv_bad = eff_pl > rsp_desc.dpl;

   always_comb begin
      st_d    = st_q;
      wr_en   = 1'b0;
      wr_idx  = tgt_idx_q;
      wr_sel  = tgt_sel_q;
      wr_desc = rsp_desc;
      done_d  = 1'b0;
      flt_d   = FLT_NONE;
      unique case (st_q)
         S_IDLE: begin
            if (start) begin
               if (in_null) begin
                  if (null_bad) begin
                     flt_d = FLT_NULL;
                  end else begin
                     wr_en   = 1'b1;
                     wr_idx  = in_idx;
                     wr_sel  = in_sel;
                     wr_desc = '0;
                     done_d  = 1'b1;
                  end
               end else begin
                  st_d = S_REQ;
               end
            end
         end
         S_REQ: begin
            if (rd_req_ready) st_d = S_WAIT;
         end
         S_WAIT: begin
            if (rd_rsp_valid) begin
               st_d = S_IDLE;
               if (priv_bad) begin
                  flt_d = FLT_PRIV;
               end else begin
                  wr_en  = 1'b1;
                  done_d = 1'b1;
               end
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         tgt_idx_q <= '0;
         tgt_sel_q <= '0;
         tgt_cs_q  <= 1'b0;
         addr_q    <= '0;
         done_q    <= 1'b0;
         flt_q     <= FLT_NONE;
      end else begin
         st_q   <= st_d;
         done_q <= done_d;
         flt_q  <= flt_d;
         if (start && !in_null) begin
            tgt_idx_q <= in_idx;
            tgt_sel_q <= in_sel;
            tgt_cs_q  <= xfer_valid;
            addr_q    <= tbl_addr;
         end
      end
   end

   assign ld_ready      = (st_q == S_IDLE);
   assign rd_req_valid  = (st_q == S_REQ);
   assign rd_req_addr   = addr_q;
   assign ld_done       = done_q;
   assign ld_fault      = (flt_q != FLT_NONE);
   assign ld_fault_code = flt_q;

endmodule

// File: rtl/seg_access_path.sv
module seg_access_path
   import seg_xlate_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [LIN_W-1:0] acc_off,
   input  seg_desc_t        desc,
   output logic             lin_valid,
   output logic [LIN_W-1:0] lin_addr,
   output logic             acc_fault,
   output logic [1:0]       acc_fault_code
);

   flt_e code_d, code_q;
   logic lin_q;
   logic [LIN_W-1:0] addr_q;

   always_comb begin
      if (!desc.valid)              code_d = FLT_NULL;
      else if (acc_off > desc.limit) code_d = FLT_LIMIT;
      else                          code_d = FLT_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lin_q  <= 1'b0;
         addr_q <= '0;
         code_q <= FLT_NONE;
      end else begin
         lin_q  <= acc_valid && (code_d == FLT_NONE);
         code_q <= acc_valid ? code_d : FLT_NONE;
         if (acc_valid) addr_q <= desc.base + acc_off;
      end
   end

   assign lin_valid      = lin_q;
   assign lin_addr       = addr_q;
   assign acc_fault      = (code_q != FLT_NONE);
   assign acc_fault_code = code_q;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int NUM_SEG = 6,
   parameter int STK_SEG = 2,
   localparam int SEG_W  = $clog2(NUM_SEG)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld_valid,
   input  logic [SEG_W-1:0]         ld_seg,
   input  logic [SEL_W-1:0]         ld_sel,
   output logic                     ld_ready,
   input  logic                     xfer_valid,
   input  logic [SEL_W-1:0]         xfer_sel,
   input  logic [LIN_W-1:0]         gdt_base,
   input  logic [LIN_W-1:0]         ldt_base,
   output logic                     rd_req_valid,
   input  logic                     rd_req_ready,
   output logic [LIN_W-1:0]         rd_req_addr,
   input  logic                     rd_rsp_valid,
   input  logic [DESC_W-1:0]        rd_rsp_data,
   output logic                     ld_done,
   output logic                     ld_fault,
   output logic [1:0]               ld_fault_code,
   input  logic                     acc_valid,
   input  logic [SEG_W-1:0]         acc_seg,
   input  logic [LIN_W-1:0]         acc_off,
   output logic                     lin_valid,
   output logic [LIN_W-1:0]         lin_addr,
   output logic                     acc_fault,
   output logic [1:0]               acc_fault_code,
   output logic [1:0]               cpl,
   output logic [NUM_SEG*SEL_W-1:0] sel_view
);

   initial begin
      assert (NUM_SEG >= 3 && NUM_SEG <= 8)
         else $error("seg_xlate_unit: NUM_SEG out of range");
      assert (STK_SEG > 0 && STK_SEG < NUM_SEG)
         else $error("seg_xlate_unit: STK_SEG out of range");
   end

   logic             wr_en;
   logic [SEG_W-1:0] wr_idx;
   logic [SEL_W-1:0] wr_sel;
   seg_desc_t        wr_desc, rd_desc;

   seg_reg_file #(.NUM_SEG(NUM_SEG)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_sel   (wr_sel),
      .wr_desc  (wr_desc),
      .rd_idx   (acc_seg),
      .rd_desc  (rd_desc),
      .cur_pl   (cpl),
      .sel_flat (sel_view)
   );

   seg_load_ctrl #(.NUM_SEG(NUM_SEG), .STK_SEG(STK_SEG)) i_load (
      .clk           (clk),
      .rst_n         (rst_n),
      .ld_valid      (ld_valid),
      .ld_seg        (ld_seg),
      .ld_sel        (ld_sel),
      .xfer_valid    (xfer_valid),
      .xfer_sel      (xfer_sel),
      .gdt_base      (gdt_base),
      .ldt_base      (ldt_base),
      .cur_pl        (cpl),
      .ld_ready      (ld_ready),
      .rd_req_valid  (rd_req_valid),
      .rd_req_ready  (rd_req_ready),
      .rd_req_addr   (rd_req_addr),
      .rd_rsp_valid  (rd_rsp_valid),
      .rd_rsp_data   (rd_rsp_data),
      .wr_en         (wr_en),
      .wr_idx        (wr_idx),
      .wr_sel        (wr_sel),
      .wr_desc       (wr_desc),
      .ld_done       (ld_done),
      .ld_fault_code (ld_fault_code),
      .ld_fault      (ld_fault)
   );

   seg_access_path i_acc (
      .clk            (clk),
      .rst_n          (rst_n),
      .acc_valid      (acc_valid),
      .acc_off        (acc_off),
      .desc           (rd_desc),
      .lin_valid      (lin_valid),
      .lin_addr       (lin_addr),
      .acc_fault      (acc_fault),
      .acc_fault_code (acc_fault_code)
   );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int NUM_SEG = 6,
   localparam int SEG_W  = $clog2(NUM_SEG)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_valid,
   input logic [SEG_W-1:0] ld_seg,
   input logic             ld_ready,
   input logic             xfer_valid,
   input logic             rd_req_valid,
   input logic             rd_req_ready,
   input logic [31:0]      rd_req_addr,
   input logic             ld_done,
   input logic             ld_fault,
   input logic             acc_valid,
   input logic             lin_valid,
   input logic             acc_fault,
   input logic [1:0]       cpl
);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R10

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> !ld_ready); // R10

   AST_ACC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(lin_valid && acc_fault)); // R9

   AST_ACC_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> lin_valid || acc_fault); // R9

   AST_LD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_done && ld_fault)); // R4

   AST_CPL_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cpl) |-> ld_done); // R5

   AST_IGNORED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ready && ld_valid && !xfer_valid && (ld_seg == '0 || int'(ld_seg) >= NUM_SEG)
      |=> !rd_req_valid && !ld_done && !ld_fault); // R6

endmodule

bind seg_xlate_unit seg_xlate_chk #(.NUM_SEG(NUM_SEG)) i_chk (.*);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;

   localparam logic [31:0] GDT = 32'h0001_0000;
   localparam logic [31:0] LDT = 32'h0002_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0, xfer_valid = 1'b0, rd_req_ready = 1'b1;
   logic        rd_rsp_valid = 1'b0, acc_valid = 1'b0;
   logic [2:0]  ld_seg = '0, acc_seg = '0;
   logic [15:0] ld_sel = '0, xfer_sel = '0;
   logic [31:0] acc_off = '0;
   logic [63:0] rd_rsp_data = '0;
   logic        ld_ready, rd_req_valid, ld_done, ld_fault, lin_valid, acc_fault;
   logic [31:0] rd_req_addr, lin_addr;
   logic [1:0]  ld_fault_code, acc_fault_code, cpl;
   logic [95:0] sel_view;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   seg_xlate_unit i_seg_xlate_unit (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
      .ld_ready(ld_ready), .xfer_valid(xfer_valid), .xfer_sel(xfer_sel),
      .gdt_base(GDT), .ldt_base(LDT), .rd_req_valid(rd_req_valid),
      .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
      .rd_rsp_data(rd_rsp_data), .ld_done(ld_done), .ld_fault(ld_fault),
      .ld_fault_code(ld_fault_code), .acc_valid(acc_valid), .acc_seg(acc_seg),
      .acc_off(acc_off), .lin_valid(lin_valid), .lin_addr(lin_addr),
      .acc_fault(acc_fault), .acc_fault_code(acc_fault_code), .cpl(cpl), .sel_view(sel_view)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input logic [31:0] base, input logic [29:0] lim,
                                      input logic [1:0] dpl);
      return {dpl, lim, base};
   endfunction

   function automatic logic [31:0] fetch_addr(input logic [15:0] sel);
      return (sel[2] ? LDT : GDT) + {16'h0, sel[15:3], 3'b000};
   endfunction

   task automatic do_load(input bit xfer, input logic [2:0] seg, input logic [15:0] sel,
                          input logic [63:0] raw, input int stall, input bit acc_now,
                          input logic [31:0] off, output logic [1:0] code, output bit done,
                          output logic [1:0] acode, output logic [31:0] alin);
      logic [31:0] want;
      want = fetch_addr(sel);
      @(negedge clk);
      if (xfer) begin xfer_valid = 1'b1; xfer_sel = sel; end
      else begin ld_valid = 1'b1; ld_seg = seg; ld_sel = sel; end
      rd_req_ready = (stall == 0);
      @(posedge clk); @(negedge clk);
      ld_valid = 1'b0; xfer_valid = 1'b0;
      check("R2 fetch request", {63'h0, rd_req_valid}, 64'h1);
      check("R2 fetch address", {32'h0, rd_req_addr}, {32'h0, want});
      check("R10 busy", {63'h0, ld_ready}, 64'h0);
      for (int i = 0; i < stall; i++) begin
         @(posedge clk); @(negedge clk);
         check("R10 request held", {31'h0, rd_req_valid, rd_req_addr}, {32'h1, want});
      end
      rd_req_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_rsp_valid = 1'b1; rd_rsp_data = raw;
      if (acc_now) begin acc_valid = 1'b1; acc_seg = seg; acc_off = off; end
      @(posedge clk); @(negedge clk);
      done  = ld_done;
      code  = ld_fault ? ld_fault_code : 2'd0;
      acode = acc_fault ? acc_fault_code : 2'd0;
      alin  = lin_addr;
      rd_rsp_valid = 1'b0; acc_valid = 1'b0;
   endtask

   task automatic do_null(input bit xfer, input logic [2:0] seg, input logic [15:0] sel,
                          output logic [1:0] code, output bit done);
      @(negedge clk);
      if (xfer) begin xfer_valid = 1'b1; xfer_sel = sel; end
      else begin ld_valid = 1'b1; ld_seg = seg; ld_sel = sel; end
      @(posedge clk); @(negedge clk);
      ld_valid = 1'b0; xfer_valid = 1'b0;
      check("R7 null needs no fetch", {63'h0, rd_req_valid}, 64'h0);
      done = ld_done;
      code = ld_fault ? ld_fault_code : 2'd0;
   endtask

   task automatic do_acc(input logic [2:0] seg, input logic [31:0] off,
                         output logic [1:0] code, output logic [31:0] lin);
      @(negedge clk);
      acc_valid = 1'b1; acc_seg = seg; acc_off = off;
      @(posedge clk); @(negedge clk);
      acc_valid = 1'b0;
      code = acc_fault ? acc_fault_code : 2'd0;
      lin  = lin_addr;
      check("R9 valid xor fault", {62'h0, lin_valid, acc_fault}, (code == 0) ? 64'h2 : 64'h1);
   endtask

   typedef struct packed {
      logic [2:0]  seg;
      logic [15:0] sel;
      logic [63:0] raw;
      logic [1:0]  ld_code;
      logic [31:0] off;
      logic [1:0]  acc_code;
      logic [31:0] lin;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{3'd1, 16'h0010, {2'd0, 30'h0000_0FFF, 32'h0000_1000}, 2'd0, 32'h10,  2'd0, 32'h0000_1010},
      '{3'd3, 16'h001F, {2'd3, 30'h0000_0100, 32'h0000_2000}, 2'd0, 32'h100, 2'd0, 32'h0000_2100},
      '{3'd4, 16'h0023, {2'd0, 30'h0000_FFFF, 32'h0000_7000}, 2'd1, 32'h1234, 2'd0, 32'h0000_1234},
      '{3'd5, 16'h0028, {2'd0, 30'h3FFF_FFFF, 32'hFFFF_FF00}, 2'd0, 32'h200, 2'd0, 32'h0000_0100},
      '{3'd2, 16'h0030, {2'd0, 30'h0000_0010, 32'h0000_8000}, 2'd0, 32'h11,  2'd2, 32'h0},
      '{3'd1, 16'h0039, {2'd2, 30'h0000_00FF, 32'h0000_0040}, 2'd0, 32'h0,   2'd0, 32'h0000_0040}
   };

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin @(posedge clk); cyc++; end
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [1:0] code, acode;
      logic [31:0] lin, alin;
      bit done;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: flat after reset
      check("R1 cpl", {62'h0, cpl}, 64'h0);
      check("R1 idle", {62'h0, ld_ready, rd_req_valid}, 64'h2);
      for (int s = 0; s < 6; s++) begin
         do_acc(3'(s), 32'hDEAD_BEEF, code, lin);
         check("R1 flat translate", {30'h0, code, lin}, {32'h0, 32'hDEAD_BEEF});
      end

      // table walk: R3, R4, R9
      for (int v = 0; v < 6; v++) begin
         do_load(1'b0, VECS[v].seg, VECS[v].sel, VECS[v].raw, 0, 1'b0, 32'h0,
                 code, done, acode, alin);
         check("R4 load result", {62'h0, code}, {62'h0, VECS[v].ld_code});
         check("R3 done pulse", {63'h0, done}, {63'h0, (VECS[v].ld_code == 2'd0)});
         if (VECS[v].ld_code == 2'd0)
            check("R3 visible selector", {48'h0, sel_view[VECS[v].seg*16 +: 16]},
                  {48'h0, VECS[v].sel});
         do_acc(VECS[v].seg, VECS[v].off, code, lin);
         check("R9 access code", {62'h0, code}, {62'h0, VECS[v].acc_code});
         if (VECS[v].acc_code == 2'd0)
            check("R9 linear address", {32'h0, lin}, {32'h0, VECS[v].lin});
      end

      // R6: ignored load targets
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         ld_valid = 1'b1; ld_seg = (k == 0) ? 3'd0 : 3'd7; ld_sel = 16'h0048;
         @(posedge clk); @(negedge clk);
         ld_valid = 1'b0;
         check("R6 no fetch", {61'h0, rd_req_valid, ld_done, ld_fault}, 64'h0);
         @(posedge clk); @(negedge clk);
         check("R6 no late effect", {61'h0, rd_req_valid, ld_done, ld_fault}, 64'h0);
      end
      check("R6 cpl kept", {62'h0, cpl}, 64'h0);
      do_acc(3'd0, 32'h77, code, lin);
      check("R6 code reg untouched", {30'h0, code, lin}, 64'h77);

      // R7: null into data register
      do_null(1'b0, 3'd1, 16'h0003, code, done);
      check("R7 null done", {61'h0, done, code}, 64'h4);
      do_acc(3'd1, 32'h4, code, lin);
      check("R7 invalid access", {62'h0, code}, 64'h3);
      do_acc(3'd6, 32'h4, code, lin);
      check("R9 bad register number", {62'h0, code}, 64'h3);

      // R12: access in the commit cycle sees old descriptor
      do_load(1'b0, 3'd1, 16'h0010, mk(32'h5000, 30'hFF, 2'd0), 0, 1'b1, 32'h10,
              code, done, acode, alin);
      check("R12 load done", {61'h0, done, code}, 64'h4);
      check("R12 same-cycle access old", {62'h0, acode}, 64'h3);
      do_acc(3'd1, 32'h10, code, lin);
      check("R12 next access new", {30'h0, code, lin}, 64'h5010);

      // R8: null into stack register
      do_null(1'b0, 3'd2, 16'h0000, code, done);
      check("R8 stack null fault", {61'h0, done, code}, 64'h3);
      do_acc(3'd2, 32'h4, code, lin);
      check("R8 stack unchanged", {30'h0, code, lin}, 64'h8004);
      do_null(1'b1, 3'd0, 16'h0002, code, done);
      check("R8 code null fault", {61'h0, done, code}, 64'h3);

      // R10: stalled request
      do_load(1'b0, 3'd3, 16'h0020, mk(32'h9000, 30'hFFFF, 2'd0), 3, 1'b0, 32'h0,
              code, done, acode, alin);
      check("R10 stalled load done", {61'h0, done, code}, 64'h4);
      do_acc(3'd3, 32'h20, code, lin);
      check("R10 stalled descriptor", {30'h0, code, lin}, 64'h9020);

      // R5: transfer raises level to 3
      do_load(1'b1, 3'd0, 16'h004B, mk(32'h0, 30'h3FFF_FFFF, 2'd3), 0, 1'b0, 32'h0,
              code, done, acode, alin);
      check("R5 transfer done", {61'h0, done, code}, 64'h4);
      check("R5 cpl follows rpl", {62'h0, cpl}, 64'h3);

      // R11: earlier load still usable at new level
      do_acc(3'd5, 32'h300, code, lin);
      check("R11 no recheck on access", {30'h0, code, lin}, 64'h200);

      // R4 at level 3
      do_load(1'b0, 3'd1, 16'h0010, mk(32'h6000, 30'hFF, 2'd2), 0, 1'b0, 32'h0,
              code, done, acode, alin);
      check("R4 cpl above dpl faults", {61'h0, done, code}, 64'h1);
      do_acc(3'd1, 32'h10, code, lin);
      check("R4 register unchanged", {30'h0, code, lin}, 64'h5010);

      // R5: transfer check uses rpl only
      do_load(1'b1, 3'd0, 16'h005A, mk(32'h0, 30'h3FFF_FFFF, 2'd1), 0, 1'b0, 32'h0,
              code, done, acode, alin);
      check("R5 rpl above dpl faults", {61'h0, done, code}, 64'h1);
      check("R5 cpl kept on fault", {62'h0, cpl}, 64'h3);
      do_load(1'b1, 3'd0, 16'h0050, mk(32'h0, 30'h3FFF_FFFF, 2'd0), 0, 1'b0, 32'h0,
              code, done, acode, alin);
      check("R5 lowering transfer done", {61'h0, done, code}, 64'h4);
      check("R5 cpl back to 0", {62'h0, cpl}, 64'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule